// File: doc/BRIEF.md
# Backlight PWM generator with locked shadow updates

This block drives a display backlight with a single pulse-width-modulated output. The period length is chosen by a period field together with a bit-count field that sets how many low bits of that field are used. The duty is a 16-bit value whose integer part sits in its top N bits. When fractional mode is on, the remaining low bits are a fraction. A per-period accumulator turns that fraction into an occasional extra high cycle, so the average duty is finer than one count.

Software writes three words through a simple write port. Writes to the period word and to the control word never change the output at once. They land in shadow registers and raise a pending flag. The shadow set is copied into the live set only when the period counter wraps, and only while the group is unlocked, so a lock lets several fields change together. A master lock input from elsewhere in the chip also holds commits, unless this group's ignore bit is set. The pending flag drops in the same cycle that the new values take effect.

Top module: `bl_pwm_lock`

## Requirements
- R1: After reset the live and shadow settings are a bit count of 12, a period of 0x0FA0, enable 1, fractional mode 1 and a duty of 0xFA00. The output is then constantly high and the pending flag is 0.
- R2: Writes are decoded by address. Address 0 is the period word: bits [15:0] hold the period and bits [20:16] the bit count. Address 1 is the control word: bits [15:0] hold the duty, bit 30 fractional mode and bit 31 enable. Address 2 is the lock word: bit 0 is the group lock and bit 1 the ignore-master-lock enable, and both take effect in the next cycle. Writes to address 3 are ignored.
- R3: N equals the bit count, and a bit count of 0 or above 16 gives N = 16. The period P is the period field masked to its low N bits. The counter runs from 0 to P-1 and then wraps to 0.
- R4: With fractional mode off, the output is high for the first D cycles of each period, where D is the duty shifted right by 16-N. Duty bits below the integer part have no effect.
- R5: When D is at least P, the output stays high for the whole period.
- R6: While the live enable is 0, the output is low.
- R7: A write to address 0 or 1 sets the pending flag in the next cycle. The shadow set is committed at the next counter wrap during which the group is not locked. The pending flag clears in that same cycle, and the new settings apply from count 0.
- R8: While the group lock is 1, no commit happens and the live duty is unchanged. After the lock clears, the held values commit at the next wrap.
- R9: While the master lock input is 1 and the ignore bit is 0, commits are held. Setting the ignore bit lets commits proceed despite the master lock.
- R10: With fractional mode on, a 16-bit accumulator adds (duty << N) mod 2^16 at every period start, and a carry adds one high cycle to that period. The accumulator is zero while the mode is off, so after switching the mode on with a fraction of one half, the periods run D, D+1, D, D+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_lock | input | 1 | Global lock that holds commits unless this group ignores it |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word select: 0 period, 1 control, 2 lock |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | Backlight PWM output |
| upd_pending | output | 1 | Shadow values wait to be committed |

## Verification
Errors in the live or shadow state show up as a wrong number of high cycles within the first period after a commit. A commit that is lost or that lands too early shows as a pending flag that stays high too long, or as a changed high count while the group is still locked. A faulty accumulator shows up one period after fractional mode is entered, when the D, D+1 alternation breaks. Each expected period is lined up on the cycle where pending falls and compared cycle by cycle.

// File: rtl/bl_pwm_lock.sv
module bl_pwm_lock #(
  parameter logic [31:0] RST_PERIOD_WORD = 32'h000C0FA0,
  parameter logic [31:0] RST_CTRL_WORD   = 32'hC000FA00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_lock,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        pwm_out,
  output logic        upd_pending
);
  localparam logic [15:0] RST_PER  = RST_PERIOD_WORD[15:0];
  localparam logic [4:0]  RST_BC   = RST_PERIOD_WORD[20:16];
  localparam logic [15:0] RST_DUTY = RST_CTRL_WORD[15:0];
  localparam logic        RST_FEN  = RST_CTRL_WORD[30];
  localparam logic        RST_EN   = RST_CTRL_WORD[31];

  function automatic logic [4:0] eff_n(input logic [4:0] bc);
    return (bc == 5'd0 || bc > 5'd16) ? 5'd16 : bc;
  endfunction

  logic [15:0] live_per, sh_per, live_duty, sh_duty;
  logic [4:0]  live_bc, sh_bc;
  logic        live_en, sh_en, live_fen, sh_fen;
  logic        lock_grp, lock_ign;
  logic [15:0] cnt, acc;
  logic        extra;

  logic [4:0]  n_live, nxt_n;
  logic [16:0] pmask;
  logic [15:0] p_live, int_live, nxt_duty, frac16;
  logic        wrap, lock_eff, commit, nxt_fen;
  logic [16:0] acc_sum, thr;

  assign n_live   = eff_n(live_bc);
  assign pmask    = (17'd1 << n_live) - 17'd1;
  assign p_live   = live_per & pmask[15:0];
  assign int_live = live_duty >> (5'd16 - n_live);
  assign wrap     = (p_live == 16'd0) || ({1'b0, cnt} + 17'd1 >= {1'b0, p_live});
  assign lock_eff = lock_grp | (master_lock & ~lock_ign);
  assign commit   = wrap & upd_pending & ~lock_eff;

  assign nxt_duty = commit ? sh_duty : live_duty;
  assign nxt_n    = eff_n(commit ? sh_bc : live_bc);
  assign nxt_fen  = commit ? sh_fen : live_fen;
  assign frac16   = nxt_duty << nxt_n;
  assign acc_sum  = {1'b0, acc} + {1'b0, frac16};

  assign thr     = {1'b0, int_live} + {16'd0, extra};
  assign pwm_out = live_en & ({1'b0, cnt} < thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_per <= RST_PER;  sh_per <= RST_PER;
      live_bc  <= RST_BC;   sh_bc  <= RST_BC;
      live_duty <= RST_DUTY; sh_duty <= RST_DUTY;
      live_en  <= RST_EN;   sh_en  <= RST_EN;
      live_fen <= RST_FEN;  sh_fen <= RST_FEN;
      lock_grp <= 1'b0;
      lock_ign <= 1'b0;
      upd_pending <= 1'b0;
      cnt   <= 16'd0;
      acc   <= 16'd0;
      extra <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            sh_per <= wr_data[15:0];
            sh_bc  <= wr_data[20:16];
          end
          2'd1: begin
            sh_duty <= wr_data[15:0];
            sh_fen  <= wr_data[30];
            sh_en   <= wr_data[31];
          end
          2'd2: begin
            lock_grp <= wr_data[0];
            lock_ign <= wr_data[1];
          end
          default: ;
        endcase
      end

      if (wr_en && !wr_addr[1]) upd_pending <= 1'b1;
      else if (commit)          upd_pending <= 1'b0;

      if (commit) begin
        live_per  <= sh_per;
        live_bc   <= sh_bc;
        live_duty <= sh_duty;
        live_en   <= sh_en;
        live_fen  <= sh_fen;
      end

      cnt <= wrap ? 16'd0 : cnt + 16'd1;

      if (wrap) begin
        if (nxt_fen) begin
          acc   <= acc_sum[15:0];
          extra <= acc_sum[16];
        end else begin
          acc   <= 16'd0;
          extra <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bl_pwm_lock_chk.sv
module bl_pwm_lock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic        upd_pending,
  input logic        pwm_out,
  input logic        live_en,
  input logic        lock_eff,
  input logic        wrap,
  input logic [15:0] live_duty,
  input logic [15:0] cnt,
  input logic [15:0] p_live
);
  assert_pending_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[1]) |=> upd_pending);

  assert_commit_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_pending) |-> $past(wrap && !lock_eff));

  assert_locked_duty_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_eff |=> $stable(live_duty));

  assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !live_en |-> !pwm_out);

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_live != 16'd0) |-> (cnt < p_live));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == 16'd0));
endmodule

bind bl_pwm_lock bl_pwm_lock_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .upd_pending(upd_pending), .pwm_out(pwm_out), .live_en(live_en),
  .lock_eff(lock_eff), .wrap(wrap), .live_duty(live_duty),
  .cnt(cnt), .p_live(p_live)
);

// File: tb/bl_pwm_lock_test.sv
`timescale 1ns/1ps
module bl_pwm_lock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        pwm_out, upd_pending;

  int n_run = 0;
  int n_fail = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  bl_pwm_lock uut (
    .clk(clk), .rst_n(rst_n), .master_lock(master_lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .upd_pending(upd_pending)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e;
    string t;
    #1;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(pwm_out === e, t, "pwm_out per cycle", int'(pwm_out), int'(e));
    end
  end

  task automatic push_period(input string tag, input int hi, input int p);
    for (int i = 0; i < p; i++) begin
      exp_q.push_back(i < hi);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_commit(input string tag);
    int guard = 0;
    while (upd_pending && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
    chk(!upd_pending, tag, "pending cleared by commit", int'(upd_pending), 0);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: defaults give constant high, no pending
    @(negedge clk);
    chk(upd_pending == 1'b0, "R1", "pending after reset", int'(upd_pending), 0);
    count_high(50, h);
    chk(h == 50, "R1", "full-on default high count", h, 50);

    // R2 R3 R4 R7: N=4, P=10, D=3
    wr(2'd0, 32'h0004_000A);
    chk(upd_pending == 1'b1, "R7", "pending after write", int'(upd_pending), 1);
    wr(2'd1, 32'h8000_3000);
    wait_commit("R7");
    for (int k = 0; k < 3; k++) push_period("R4", 3, 10);
    drain();

    // R4: fraction bits ignored when fractional mode off
    wr(2'd1, 32'h8000_3FFF);
    wait_commit("R4");
    for (int k = 0; k < 3; k++) push_period("R4", 3, 10);
    drain();

    // R8: group lock holds the live duty
    wr(2'd2, 32'h1);
    wr(2'd1, 32'h8000_7000);
    count_high(40, h);
    chk(h == 12, "R8", "high count while locked", h, 12);
    chk(upd_pending == 1'b1, "R8", "pending held while locked", int'(upd_pending), 1);
    wr(2'd2, 32'h0);
    wait_commit("R8");
    for (int k = 0; k < 2; k++) push_period("R8", 7, 10);
    drain();

    // R9: master lock holds, ignore bit releases
    @(negedge clk); master_lock = 1'b1;
    wr(2'd1, 32'h8000_5000);
    count_high(40, h);
    chk(h == 28, "R9", "high count under master lock", h, 28);
    chk(upd_pending == 1'b1, "R9", "pending under master lock", int'(upd_pending), 1);
    wr(2'd2, 32'h2);
    wait_commit("R9");
    for (int k = 0; k < 2; k++) push_period("R9", 5, 10);
    drain();
    @(negedge clk); master_lock = 1'b0;
    wr(2'd2, 32'h0);

    // R6: disabled output low
    wr(2'd1, 32'h0000_5000);
    wait_commit("R6");
    for (int k = 0; k < 2; k++) push_period("R6", 0, 10);
    drain();

    // R5: duty above period gives constant high
    wr(2'd1, 32'h8000_C000);
    wait_commit("R5");
    for (int k = 0; k < 2; k++) push_period("R5", 10, 10);
    drain();

    // R3: bit count 0 means 16 bits
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0000_0014);
    wr(2'd1, 32'h8000_0006);
    wr(2'd2, 32'h0);
    wait_commit("R3");
    for (int k = 0; k < 2; k++) push_period("R3", 6, 20);
    drain();

    // R3: period field masked to N bits (0xFFF5 with N=4 -> 5)
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0004_FFF5);
    wr(2'd1, 32'h8000_2000);
    wr(2'd2, 32'h0);
    wait_commit("R3");
    for (int k = 0; k < 3; k++) push_period("R3", 2, 5);
    drain();

    // R10: fraction one half -> 3,4,3,4
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0004_000A);
    wr(2'd1, 32'hC000_3800);
    wr(2'd2, 32'h0);
    wait_commit("R10");
    push_period("R10", 3, 10);
    push_period("R10", 4, 10);
    push_period("R10", 3, 10);
    push_period("R10", 4, 10);
    drain();

    // R10: mode off clears accumulator, quarter -> 3,3,3,4
    wr(2'd1, 32'h8000_3000);
    wait_commit("R10");
    wr(2'd1, 32'hC000_3400);
    wait_commit("R10");
    push_period("R10", 3, 10);
    push_period("R10", 3, 10);
    push_period("R10", 3, 10);
    push_period("R10", 4, 10);
    drain();

    // R2: address 3 ignored
    wr(2'd3, 32'h0000_0000);
    chk(upd_pending == 1'b0, "R2", "pending after address 3 write", int'(upd_pending), 0);
    count_high(40, h);
    chk(h == 13, "R2", "high count unchanged after address 3 write", h, 13);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule